// File: doc/BRIEF.md
# Prescaled LED PWM Generator

This block drives a single active-high LED pin from an 8-bit pulse-width modulator. The modulator counter steps once every 2^PRE_W × (LD + 1) ticks of the selected input tick. PRE_W is 8 by default, so the step divider is 256 × (LD + 1) and the PWM frequency is Fin / (256 × (LD + 1)). Two tick sources are modelled as clock enables on the one system clock: a slow tick (nominally 32768 Hz, the reset default) and a fast tick (nominally 48 MHz). One configuration bit selects between them.

Software reaches the block through three registers with plain write and read strobes. A new duty value takes effect at once. A new prescale value LD is parked in a holding register. It reaches the active prescaler only after software requests a transfer, and only at the next wrap of the 8-bit counter, so a period is never cut short. Two explicit modes, OFF and ALWAYS_ON, override the modulator. Duty values 0 and 255 give a solid low and a solid high.

Top module: `lamp_pwm`

## Requirements
- R1: After reset the LED is low and every register reads 0: mode OFF, slow source, duty 0, held delay 0, no transfer pending.
- R2: In OFF mode (mode code 0) the LED is low, and the prescaler and the 8-bit counter are cleared to zero. Re-entering PWM mode therefore starts a period from counter value 0.
- R3: In ALWAYS_ON mode (mode code 1) the LED is high. The counters hold their values.
- R4: In PWM mode (mode code 2 or 3) the 8-bit counter advances once every 2^PRE_W × (LD+1) selected ticks and wraps from 255 to 0. The LED is high while the counter is below the duty value.
- R5: In PWM mode a duty of 0 keeps the LED low for the whole period, and a duty of 255 keeps it high for the whole period, including counter value 255.
- R6: A write to the duty field changes the LED comparison from the cycle after the write.
- R7: A write to the delay register only loads the holding register. Reading the register returns the held value, and the active prescale value does not change.
- R8: Writing the configuration register with bit 3 set marks a transfer as pending, and bit 3 reads 1 while it is pending. At the next counter wrap (255 to 0) the held value becomes the active prescale value and the pending bit clears. The new value governs the period that starts at that wrap.
- R9: Configuration bit 2 selects the tick source: 0 for the slow tick, 1 for the fast tick. Ticks of the unselected source do not advance the prescaler.
- R10: Register map. Address 0 is configuration: bits [1:0] mode, bit 2 source, bit 3 update. Address 1 holds the duty in bits [7:0]. Address 2 holds the held delay in bits [11:0]. Unused bits read 0. Address 3 reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_slow_i | input | 1 | Slow tick enable (nominal 32768 Hz) |
| tick_fast_i | input | 1 | Fast tick enable (nominal 48 MHz) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| led_o | output | 1 | LED drive, active high |

## Verification
The assertions assume that the tick inputs are single-cycle-wide enables sampled on the system clock. They also assume that the register strobe carries a stable address and stable data for the cycle it is high. Under these conditions the counter either holds or steps by exactly one. The bench drives every input one time unit after a rising edge and keeps writes to a single cycle each. It holds the fast tick high continuously and switches the slow tick between fully off and fully on, so that every expected edge position is an exact cycle count. It uses a reduced PRE_W of 2 so that several full periods fit in a short run.

// File: rtl/lamp_pwm_pkg.sv
package lamp_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ON   = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_PWM2 = 2'd3
  } lamp_mode_e;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_LIM = 2'd1;
  localparam logic [1:0] ADDR_DLY = 2'd2;

  localparam int CFG_SRC_BIT = 2;
  localparam int CFG_UPD_BIT = 3;

endpackage

// File: rtl/lamp_pwm_regs.sv
module lamp_pwm_regs
  import lamp_pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int LD_W   = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output lamp_mode_e        mode_o,
  output logic              fast_o,
  output logic              upd_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [LD_W-1:0]   ld_act_o,
  output logic [DATA_W-1:0] rdata_o
);

  lamp_mode_e        mode_q, mode_d;
  logic              fast_q, fast_d;
  logic              upd_q, upd_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [LD_W-1:0]   hold_q, hold_d;
  logic [LD_W-1:0]   act_q, act_d;

  always_comb begin
    mode_d = mode_q;
    fast_d = fast_q;
    upd_d  = upd_q;
    duty_d = duty_q;
    hold_d = hold_q;
    act_d  = act_q;
    if (wrap_i && upd_q) begin
      act_d = hold_q;
      upd_d = 1'b0;
    end
    if (wr_i) begin
      case (addr_i)
        ADDR_CFG: begin
          mode_d = lamp_mode_e'(wdata_i[1:0]);
          fast_d = wdata_i[CFG_SRC_BIT];
          if (wdata_i[CFG_UPD_BIT]) upd_d = 1'b1;
        end
        ADDR_LIM: duty_d = wdata_i[DUTY_W-1:0];
        ADDR_DLY: hold_d = wdata_i[LD_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      fast_q <= 1'b0;
      upd_q  <= 1'b0;
      duty_q <= '0;
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      mode_q <= mode_d;
      fast_q <= fast_d;
      upd_q  <= upd_d;
      duty_q <= duty_d;
      hold_q <= hold_d;
      act_q  <= act_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CFG: begin
        rdata_o[1:0]         = mode_q;
        rdata_o[CFG_SRC_BIT] = fast_q;
        rdata_o[CFG_UPD_BIT] = upd_q;
      end
      ADDR_LIM: rdata_o[DUTY_W-1:0] = duty_q;
      ADDR_DLY: rdata_o[LD_W-1:0]   = hold_q;
      default: ;
    endcase
  end

  assign mode_o   = mode_q;
  assign fast_o   = fast_q;
  assign upd_o    = upd_q;
  assign duty_o   = duty_q;
  assign ld_act_o = act_q;

endmodule

// File: rtl/lamp_pwm_prescaler.sv
module lamp_pwm_prescaler #(
  parameter int PRE_W = 8,
  parameter int LD_W  = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [LD_W-1:0] ld_i,
  output logic            step_o
);

  localparam int CNT_W = PRE_W + LD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             adv;

  assign limit  = {ld_i, {PRE_W{1'b1}}};
  assign adv    = run_i && tick_i;
  assign step_o = adv && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (step_o) cnt_d = '0;
    else if (adv)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lamp_pwm_core.sv
module lamp_pwm_core
  import lamp_pwm_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  lamp_mode_e        mode_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              wrap_o,
  output logic [DUTY_W-1:0] cnt_o,
  output logic              led_o
);

  logic [DUTY_W-1:0] cnt_q, cnt_d;

  assign wrap_o = step_i && (cnt_q == {DUTY_W{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    case (mode_i)
      MODE_OFF: led_o = 1'b0;
      MODE_ON:  led_o = 1'b1;
      default:  led_o = (duty_i == {DUTY_W{1'b1}}) ? 1'b1 : (cnt_q < duty_i);
    endcase
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/lamp_pwm.sv
module lamp_pwm
  import lamp_pwm_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int DUTY_W = 8,
  parameter int LD_W   = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              led_o
);

  lamp_mode_e        mode;
  logic              fast_sel;
  logic              upd_pend;
  logic [DUTY_W-1:0] duty;
  logic [LD_W-1:0]   ld_act;
  logic              run;
  logic              clr;
  logic              tick_sel;
  logic              step;
  logic              wrap;
  logic [DUTY_W-1:0] pwm_cnt;

  assign run      = (mode == MODE_PWM) || (mode == MODE_PWM2);
  assign clr      = (mode == MODE_OFF);
  assign tick_sel = fast_sel ? tick_fast_i : tick_slow_i;

  lamp_pwm_regs #(
    .DUTY_W(DUTY_W), .LD_W(LD_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .wrap_i  (wrap),
    .mode_o  (mode),
    .fast_o  (fast_sel),
    .upd_o   (upd_pend),
    .duty_o  (duty),
    .ld_act_o(ld_act),
    .rdata_o (reg_rdata_o)
  );

  lamp_pwm_prescaler #(
    .PRE_W(PRE_W), .LD_W(LD_W)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (clr),
    .tick_i(tick_sel),
    .ld_i  (ld_act),
    .step_o(step)
  );

  lamp_pwm_core #(
    .DUTY_W(DUTY_W)
  ) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .step_i(step),
    .mode_i(mode),
    .duty_i(duty),
    .wrap_o(wrap),
    .cnt_o (pwm_cnt),
    .led_o (led_o)
  );

endmodule

// File: rtl/lamp_pwm_chk.sv
module lamp_pwm_chk #(
  parameter int DUTY_W = 8,
  parameter int LD_W   = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode,
  input logic [DUTY_W-1:0] duty,
  input logic [DUTY_W-1:0] pwm_cnt,
  input logic              led_o,
  input logic              run,
  input logic              step,
  input logic              upd_pend,
  input logic              wrap,
  input logic [LD_W-1:0]   ld_act
);

  assert_off_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd0) |-> !led_o);

  assert_off_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd0) |=> (pwm_cnt == '0));

  assert_on_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd1) |-> led_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !step) |=> $stable(pwm_cnt));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (pwm_cnt == DUTY_W'($past(pwm_cnt) + 1'b1)));

  assert_duty_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[1] && duty == '0) |-> !led_o);

  assert_duty_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[1] && duty == {DUTY_W{1'b1}}) |-> led_o);

  assert_upd_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(upd_pend) |-> $past(wrap));

  assert_ld_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ld_act) |-> $past(wrap));

endmodule

bind lamp_pwm lamp_pwm_chk #(
  .DUTY_W(DUTY_W), .LD_W(LD_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode    (mode),
  .duty    (duty),
  .pwm_cnt (pwm_cnt),
  .led_o   (led_o),
  .run     (run),
  .step    (step),
  .upd_pend(upd_pend),
  .wrap    (wrap),
  .ld_act  (ld_act)
);

// File: tb/sim_lamp_pwm.sv
module sim_lamp_pwm;

  localparam int CLK_PERIOD = 10;
  localparam int TB_PRE_W   = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_slow_i = 1'b0;
  logic        tick_fast_i = 1'b1;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = 16'd0;
  logic [15:0] reg_rdata_o;
  logic        led_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lamp_pwm #(.PRE_W(TB_PRE_W)) u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_slow_i(tick_slow_i),
    .tick_fast_i(tick_fast_i),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .led_o      (led_o)
  );

  int unsigned cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct {
    int unsigned at;
    bit          is_rd;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  int unsigned e_cyc = 0;
  logic [15:0] got;

  // Monitor: compare every expected item due at this cycle
  always @(negedge clk_i) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        checks++;
        got = sb[i].is_rd ? reg_rdata_o : {15'd0, led_o};
        if (got !== sb[i].val) begin
          errors++;
          $display("FAIL %s cycle %0d: actual=%h expected=%h", sb[i].tag, cyc, got, sb[i].val);
        end
        sb.delete(i);
      end else if (sb[i].at < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s missed at cycle %0d: actual=none expected=%h", sb[i].tag, sb[i].at, sb[i].val);
        sb.delete(i);
      end
    end
  end

  task automatic push(input int unsigned at, input bit is_rd, input logic [15:0] val, input string tag);
    exp_t it;
    it.at = at; it.is_rd = is_rd; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_led(input int unsigned at, input logic v, input string tag);
    push(at, 1'b0, {15'd0, v}, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0;
    e_cyc = cyc;
  endtask

  task automatic rd_now(input logic [1:0] a, input logic [15:0] v, input string tag);
    reg_addr_i = a;
    push(cyc, 1'b1, v, tag);
    @(posedge clk_i); #1;
  endtask

  task automatic wait_until(input int unsigned t);
    while (cyc < t) begin
      @(posedge clk_i); #1;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    int unsigned base, t, s;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1: reset state
    exp_led(cyc, 1'b0, "R1 led");
    rd_now(2'd0, 16'h0000, "R1 cfg");
    rd_now(2'd1, 16'h0000, "R1 lim");
    rd_now(2'd2, 16'h0000, "R1 dly");

    // R3: always on
    wr(2'd0, 16'h0001);
    exp_led(e_cyc, 1'b1, "R3 on");
    exp_led(e_cyc + 50, 1'b1, "R3 on late");
    wait_until(e_cyc + 51);

    // R4: PWM fast, LD=0, duty 3 -> 4 cycles per step, 1024 per period
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0006);
    base = e_cyc;
    exp_led(base, 1'b1, "R4 start");
    exp_led(base + 11, 1'b1, "R4 last high");
    exp_led(base + 12, 1'b0, "R4 first low");
    exp_led(base + 1023, 1'b0, "R4 period end");
    exp_led(base + 1024, 1'b1, "R4 wrap");
    exp_led(base + 1035, 1'b1, "R4 wrap high");
    exp_led(base + 1036, 1'b0, "R4 wrap low");
    rd_now(2'd0, 16'h0006, "R10 cfg readback");

    // R6: duty write acts on the next cycle (counter 25 at this point)
    wait_until(base + 1124);
    exp_led(cyc, 1'b0, "R6 before");
    wr(2'd1, 16'd200);
    exp_led(e_cyc, 1'b1, "R6 after");

    // R5: duty endpoints
    wr(2'd1, 16'd0);
    exp_led(e_cyc, 1'b0, "R5 zero");
    exp_led(e_cyc + 200, 1'b0, "R5 zero late");
    wait_until(e_cyc + 201);
    wr(2'd1, 16'd255);
    exp_led(e_cyc, 1'b1, "R5 full");
    exp_led(base + 2047, 1'b1, "R5 full at 255");
    exp_led(base + 2050, 1'b1, "R5 full after wrap");
    wait_until(base + 2060);

    // R7: delay write held only
    wr(2'd2, 16'd1);
    rd_now(2'd2, 16'h0001, "R7 held readback");
    rd_now(2'd0, 16'h0006, "R7 no pending");
    wr(2'd1, 16'd3);
    exp_led(base + 3072 + 11, 1'b1, "R7 period unchanged high");
    exp_led(base + 3072 + 12, 1'b0, "R7 period unchanged low");
    wait_until(base + 3072 + 13);

    // R8: transfer at next wrap
    wr(2'd0, 16'h000E);
    rd_now(2'd0, 16'h000E, "R8 pending");
    reg_addr_i = 2'd0;
    t = base + 4096;
    push(t - 1, 1'b1, 16'h000E, "R8 pending before wrap");
    push(t, 1'b1, 16'h0006, "R8 cleared at wrap");
    exp_led(t + 23, 1'b1, "R8 new step high");
    exp_led(t + 24, 1'b0, "R8 new step low");
    exp_led(t + 2047, 1'b0, "R8 new period end");
    exp_led(t + 2048, 1'b1, "R8 new period wrap");
    wait_until(t + 2050);

    // R2: OFF clears counters, restart from phase zero
    wr(2'd0, 16'h0004);
    exp_led(e_cyc, 1'b0, "R2 off");
    exp_led(e_cyc + 5, 1'b0, "R2 off late");
    wait_until(e_cyc + 10);
    wr(2'd0, 16'h0006);
    exp_led(e_cyc + 23, 1'b1, "R2 restart high");
    exp_led(e_cyc + 24, 1'b0, "R2 restart low");
    wait_until(e_cyc + 30);

    // R9: slow source, fast ticks ignored
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0002);
    exp_led(e_cyc + 500, 1'b1, "R9 frozen without slow ticks");
    wait_until(e_cyc + 600);
    tick_slow_i = 1'b1;
    s = cyc;
    exp_led(s + 23, 1'b1, "R9 slow high");
    exp_led(s + 24, 1'b0, "R9 slow low");
    wait_until(s + 30);

    // R10: address 3 and unused bits
    wr(2'd3, 16'hFFFF);
    rd_now(2'd3, 16'h0000, "R10 addr3");
    rd_now(2'd0, 16'h0002, "R10 cfg after addr3 write");
    wr(2'd0, 16'hFFF2);
    rd_now(2'd0, 16'h0002, "R10 cfg unused bits");
    wr(2'd2, 16'hF00A);
    rd_now(2'd2, 16'h000A, "R10 dly unused bits");
    wr(2'd1, 16'hAB55);
    rd_now(2'd1, 16'h0055, "R10 lim unused bits");

    repeat (3) begin
      @(posedge clk_i); #1;
    end
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual=%0d left expected=0", sb.size());
    end
    finish_run();
  end

endmodule